// File: doc/BRIEF.md
# Start-Stop Serial Port with Multiprocessor Flag and Break

This block sends and receives 8-bit characters on a start-stop serial line. It has one transmit output and one receive input. A host writes one character at a time into the transmitter. The transmitter frames the character with a start bit, optional parity, an optional multiprocessor flag bit and a stop bit, then shifts it out least significant bit first. The host can also hold the line low to signal a break.

The receiver looks for the falling edge of a start bit. In the oversampled modes it confirms the start bit at half a bit period and then samples every bit in its centre. It checks parity and the stop bit, recognises an all-low frame as a break, and stores each character in a receive buffer. Each stored character has a 5-bit status word beside it. The host reads the buffer through a show-ahead port. The bit period is 1, 16, 32 or 64 input clocks, selected by `div_sel`.

Top module: `sio_port`

## Requirements
- R1: After reset, `txd` is 1, `tx_busy` is 0, `rx_empty` is 1 and `rx_full` is 0.
- R2: A write (`tx_we`) while the transmitter is idle sends, in order: a start bit (0), the 8 data bits LSB first, the parity bit if parity is enabled, the `tx_mp` bit if `mp_en` is 1, and a stop bit (1). `tx_busy` stays high until the stop bit has lasted one full bit period. When the transmitter is idle and no break is requested, `txd` is 1.
- R3: The parity encoding is set by `par_mode`: 0 means no parity bit, 1 means even parity (the parity bit is the XOR of the data bits), 2 means odd parity (the inverse of that XOR), and 3 means no parity bit.
- R4: The bit period is set by `div_sel`: 0 gives 1 clock, 1 gives 16 clocks, 2 gives 32 clocks and 3 gives 64 clocks. The setting applies to both directions.
- R5: The receiver samples each bit at mid-period. In the oversampled modes, a low pulse on `rxd` shorter than half a bit period does not start a character.
- R6: Each received character is stored with a status word `rx_stat`. Its bits are: bit 0 = the received multiprocessor bit (0 when `mp_en` is 0), bit 1 = parity error, bit 2 = framing error (stop bit sampled low), bit 3 = overrun, bit 4 = break.
- R7: A frame in which every sampled bit is low, stop bit included, is stored as data 0 with status 5'b10000. The receiver then waits for `rxd` to return high before it looks for another start bit.
- R8: While `brk_send` is 1 and the transmitter is idle, `txd` is 0. A `tx_we` pulse in that state is ignored.
- R9: The receive buffer holds 32 characters in arrival order. `rx_data` and `rx_stat` show the oldest entry, and a pulse on `rx_re` removes it. `rx_full` is 1 exactly when 32 entries are held.
- R10: A character that completes while the buffer is full is discarded. The next character that is stored carries the overrun bit (`rx_stat` bit 3).
- R11: A pulse on `rx_re` while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 2 | Bit period select: 1, 16, 32 or 64 clocks |
| par_mode | input | 2 | Parity: 0 none, 1 even, 2 odd, 3 none |
| mp_en | input | 1 | Add a multiprocessor bit to every frame |
| tx_we | input | 1 | Write strobe for the transmit character |
| tx_data | input | 8 | Character to send |
| tx_mp | input | 1 | Multiprocessor bit to send |
| brk_send | input | 1 | Hold the line low while the transmitter is idle |
| tx_busy | output | 1 | A frame is being sent |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_re | input | 1 | Remove the oldest received character |
| rx_data | output | 8 | Oldest received character |
| rx_stat | output | 5 | Status of the oldest character |
| rx_empty | output | 1 | Receive buffer is empty |
| rx_full | output | 1 | Receive buffer holds 32 characters |

## Verification
The transmitter is run through every combination of bit period, parity mode and multiprocessor setting. Each frame is compared bit by bit at mid-period, which tells a wrong bit order, a wrong parity sense, a misplaced flag bit and a wrong divide ratio apart. The receiver gets the same sweep with frames built by the bench. Some frames have a flipped parity bit and some have a low stop bit, so each error flag is seen set and clear in every mode. Separate runs cover a short start glitch, an all-low break frame in odd-parity mode (where a parity error must not be reported), a full buffer followed by a discarded character, and a read from an empty buffer.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int DATA_W = 8;
    localparam int STAT_W = 5;
    localparam int CNT_W  = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_MP,
        PH_STOP,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        logic brk;
        logic ovr;
        logic ferr;
        logic perr;
        logic mp;
    } rx_stat_t;

    // last count value of one bit period
    function automatic logic [CNT_W-1:0] bit_last(input logic [1:0] sel);
        case (sel)
            2'd0:    return CNT_W'(0);
            2'd1:    return CNT_W'(15);
            2'd2:    return CNT_W'(31);
            default: return CNT_W'(63);
        endcase
    endfunction

    // last count value of half a bit period, used to reach mid-bit
    function automatic logic [CNT_W-1:0] half_last(input logic [1:0] sel);
        case (sel)
            2'd1:    return CNT_W'(7);
            2'd2:    return CNT_W'(15);
            2'd3:    return CNT_W'(31);
            default: return CNT_W'(0);
        endcase
    endfunction

    function automatic logic par_on(input logic [1:0] mode);
        return (mode == 2'd1) || (mode == 2'd2);
    endfunction

    function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic [1:0] mode);
        return (mode == 2'd2) ? ~(^d) : ^d;
    endfunction

endpackage

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        div_sel,
    input  logic [1:0]        par_mode,
    input  logic              mp_en,
    input  logic              brk_send,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_mp,
    output logic              txd,
    output logic              tx_busy
);

    typedef struct packed {
        phase_t            ph;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        idx;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              mp;
    } tx_state_t;

    tx_state_t q, d;

    always_comb begin
        d = q;
        if (q.ph == PH_IDLE) begin
            if (tx_we && !brk_send) begin
                d.ph  = PH_START;
                d.cnt = bit_last(div_sel);
                d.sh  = tx_data;
                d.par = par_bit(tx_data, par_mode);
                d.mp  = tx_mp;
                d.idx = 3'd0;
            end
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - CNT_W'(1);
        end else begin
            d.cnt = bit_last(div_sel);
            case (q.ph)
                PH_START: begin
                    d.ph  = PH_DATA;
                    d.idx = 3'd0;
                end
                PH_DATA: begin
                    d.sh  = {1'b0, q.sh[DATA_W-1:1]};
                    d.idx = q.idx + 3'd1;
                    if (q.idx == 3'd7) begin
                        if (par_on(par_mode)) d.ph = PH_PAR;
                        else if (mp_en)       d.ph = PH_MP;
                        else                  d.ph = PH_STOP;
                    end
                end
                PH_PAR:  d.ph = mp_en ? PH_MP : PH_STOP;
                PH_MP:   d.ph = PH_STOP;
                default: d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.ph)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = q.sh[0];
            PH_PAR:   txd = q.par;
            PH_MP:    txd = q.mp;
            PH_STOP:  txd = 1'b1;
            default:  txd = !brk_send;
        endcase
    end

    assign tx_busy = (q.ph != PH_IDLE);

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        div_sel,
    input  logic [1:0]        par_mode,
    input  logic              mp_en,
    input  logic              rxd,
    input  logic              fifo_full,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output rx_stat_t          push_stat
);

    typedef struct packed {
        phase_t            ph;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        idx;
        logic [DATA_W-1:0] sh;
        logic              perr;
        logic              mp;
        logic              seen1;
        logic              ovr_pend;
        logic              push;
        logic [DATA_W-1:0] wdata;
        rx_stat_t          wstat;
    } rx_state_t;

    rx_state_t q, d;

    always_comb begin
        rx_stat_t st;
        logic     brk;
        st     = '0;
        brk    = 1'b0;
        d      = q;
        d.push = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (!rxd) begin
                    d.ph    = (div_sel == 2'd0) ? PH_DATA : PH_START;
                    d.cnt   = half_last(div_sel);
                    d.idx   = 3'd0;
                    d.perr  = 1'b0;
                    d.mp    = 1'b0;
                    d.seen1 = 1'b0;
                end
            end
            PH_HOLD: begin
                if (rxd) d.ph = PH_IDLE;
            end
            default: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CNT_W'(1);
                end else begin
                    d.cnt = bit_last(div_sel);
                    case (q.ph)
                        PH_START: d.ph = rxd ? PH_IDLE : PH_DATA;
                        PH_DATA: begin
                            d.sh    = {rxd, q.sh[DATA_W-1:1]};
                            d.seen1 = q.seen1 | rxd;
                            d.idx   = q.idx + 3'd1;
                            if (q.idx == 3'd7) begin
                                if (par_on(par_mode)) d.ph = PH_PAR;
                                else if (mp_en)       d.ph = PH_MP;
                                else                  d.ph = PH_STOP;
                            end
                        end
                        PH_PAR: begin
                            d.perr  = (rxd != par_bit(q.sh, par_mode));
                            d.seen1 = q.seen1 | rxd;
                            d.ph    = mp_en ? PH_MP : PH_STOP;
                        end
                        PH_MP: begin
                            d.mp    = rxd;
                            d.seen1 = q.seen1 | rxd;
                            d.ph    = PH_STOP;
                        end
                        default: begin
                            brk     = !q.seen1 && !rxd;
                            st.brk  = brk;
                            st.ferr = !rxd && !brk;
                            st.perr = q.perr && !brk;
                            st.mp   = q.mp && !brk;
                            if (fifo_full) begin
                                d.ovr_pend = 1'b1;
                            end else begin
                                st.ovr     = q.ovr_pend;
                                d.ovr_pend = 1'b0;
                                d.push     = 1'b1;
                                d.wdata    = q.sh;
                                d.wstat    = st;
                            end
                            d.ph = brk ? PH_HOLD : PH_IDLE;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign push      = q.push;
    assign push_data = q.wdata;
    assign push_stat = q.wstat;

endmodule

// File: rtl/sio_rxbuf.sv
module sio_rxbuf
    import sio_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STAT_W-1:0] wstat,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [STAT_W-1:0] rstat,
    output logic              empty,
    output logic              full
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t q, d;
    logic [DATA_W-1:0] dmem [DEPTH];
    logic [STAT_W-1:0] smem [DEPTH];
    logic do_push, do_pop;

    assign do_push = push && (q.cnt != FULL_CNT);
    assign do_pop  = pop && (q.cnt != '0);

    always_comb begin
        d = q;
        if (do_push) d.wp = q.wp + AW'(1);
        if (do_pop)  d.rp = q.rp + AW'(1);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + (AW+1)'(1);
            2'b01:   d.cnt = q.cnt - (AW+1)'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            dmem[q.wp] <= wdata;
            smem[q.wp] <= wstat;
        end
    end

    assign rdata = dmem[q.rp];
    assign rstat = smem[q.rp];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == FULL_CNT);

endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int RX_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        div_sel,
    input  logic [1:0]        par_mode,
    input  logic              mp_en,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_mp,
    input  logic              brk_send,
    output logic              tx_busy,
    output logic              txd,
    input  logic              rxd,
    input  logic              rx_re,
    output logic [DATA_W-1:0] rx_data,
    output logic [STAT_W-1:0] rx_stat,
    output logic              rx_empty,
    output logic              rx_full
);

    logic              push;
    logic [DATA_W-1:0] push_data;
    rx_stat_t          push_stat;

    sio_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .par_mode (par_mode),
        .mp_en    (mp_en),
        .brk_send (brk_send),
        .tx_we    (tx_we),
        .tx_data  (tx_data),
        .tx_mp    (tx_mp),
        .txd      (txd),
        .tx_busy  (tx_busy)
    );

    sio_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_sel   (div_sel),
        .par_mode  (par_mode),
        .mp_en     (mp_en),
        .rxd       (rxd),
        .fifo_full (rx_full),
        .push      (push),
        .push_data (push_data),
        .push_stat (push_stat)
    );

    sio_rxbuf #(.DEPTH(RX_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (push_data),
        .wstat (push_stat),
        .pop   (rx_re),
        .rdata (rx_data),
        .rstat (rx_stat),
        .empty (rx_empty),
        .full  (rx_full)
    );

endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_we,
    input logic brk_send,
    input logic tx_busy,
    input logic txd,
    input logic rx_re,
    input logic rx_empty,
    input logic rx_full
);

    assert_idle_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !brk_send) |-> txd);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && brk_send) |-> !txd);

    assert_start_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(tx_we && !brk_send));

    assert_full_not_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_empty);

    assert_empty_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_empty) |-> $past(rx_re));

endmodule

bind sio_port sio_port_chk i_sio_port_chk (.*);

// File: tb/test_sio_port.sv
module test_sio_port;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [1:0] par_mode = 2'd0;
    logic       mp_en = 1'b0;
    logic       tx_we = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_mp = 1'b0;
    logic       brk_send = 1'b0;
    logic       tx_busy, txd;
    logic       rxd = 1'b1;
    logic       rx_re = 1'b0;
    logic [7:0] rx_data;
    logic [4:0] rx_stat;
    logic       rx_empty, rx_full;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sio_port i_sio_port (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .par_mode(par_mode),
        .mp_en(mp_en), .tx_we(tx_we), .tx_data(tx_data), .tx_mp(tx_mp),
        .brk_send(brk_send), .tx_busy(tx_busy), .txd(txd), .rxd(rxd),
        .rx_re(rx_re), .rx_data(rx_data), .rx_stat(rx_stat),
        .rx_empty(rx_empty), .rx_full(rx_full)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int div_of(input logic [1:0] sel);
        case (sel)
            2'd0: return 1;
            2'd1: return 16;
            2'd2: return 32;
            default: return 64;
        endcase
    endfunction

    // frame bits in line order; returns bit count
    function automatic int build(input logic [7:0] d, input logic [1:0] pm, input logic me,
                                 input logic mpb, input logic flip, input logic stopv,
                                 output logic [11:0] bits);
        int nb = 0;
        bits = '0;
        bits[nb] = 1'b0; nb++;
        for (int i = 0; i < 8; i++) begin bits[nb] = d[i]; nb++; end
        if (pm == 2'd1) begin bits[nb] = (^d) ^ flip; nb++; end
        if (pm == 2'd2) begin bits[nb] = ~(^d) ^ flip; nb++; end
        if (me) begin bits[nb] = mpb; nb++; end
        bits[nb] = stopv; nb++;
        return nb;
    endfunction

    // R2 R3 R4: send one character and compare txd at every mid-bit
    task automatic tx_frame(input logic [1:0] sel, input logic [1:0] pm, input logic me,
                            input logic [7:0] d, input logic mpb);
        logic [11:0] exp_bits, cap;
        int nb, n, k;
        bit busy_ok;
        n = div_of(sel);
        nb = build(d, pm, me, mpb, 1'b0, 1'b1, exp_bits);
        cap = '0;
        busy_ok = 1'b1;
        @(negedge clk);
        div_sel = sel; par_mode = pm; mp_en = me;
        tx_data = d; tx_mp = mpb; tx_we = 1'b1;
        k = 0;
        for (int b = 0; b < nb; b++) begin
            while (k < b*n + n/2 + 1) begin
                @(negedge clk); k++;
                if (k == 1) tx_we = 1'b0;
            end
            cap[b] = txd;
            busy_ok = busy_ok && tx_busy;
        end
        check(cap == exp_bits, "R2/R3/R4 tx frame", int'(cap), int'(exp_bits));
        check(busy_ok, "R2 busy during frame", 0, 1);
        while (k < nb*n + 1) begin @(negedge clk); k++; end
        check(!tx_busy && txd, "R2/R4 idle after stop period", int'({tx_busy, txd}), 1);
    endtask

    task automatic drive_rx(input logic [11:0] bits, input int nb, input int n);
        for (int b = 0; b < nb; b++) begin
            rxd = bits[b];
            repeat (n) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pop_check(input logic [7:0] ed, input logic [4:0] es, input string req);
        check(!rx_empty, req, int'(rx_empty), 0);
        check(rx_data == ed, req, int'(rx_data), int'(ed));
        check(rx_stat == es, req, int'(rx_stat), int'(es));
        rx_re = 1'b1;
        @(negedge clk);
        rx_re = 1'b0;
    endtask

    // R5 R6 R4: receive one bench-built character
    task automatic rx_frame(input logic [1:0] sel, input logic [1:0] pm, input logic me,
                            input logic [7:0] d, input logic mpb, input logic flip, input logic stopv);
        logic [11:0] bits;
        logic [4:0]  es;
        int nb;
        bit pon;
        nb = build(d, pm, me, mpb, flip, stopv, bits);
        pon = (pm == 2'd1) || (pm == 2'd2);
        es = {1'b0, 1'b0, !stopv, flip && pon, me && mpb};
        @(negedge clk);
        div_sel = sel; par_mode = pm; mp_en = me;
        drive_rx(bits, nb, div_of(sel));
        pop_check(d, es, "R5/R6/R4 rx char");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
        check(tx_busy == 1'b0, "R1 busy after reset", int'(tx_busy), 0);
        check(rx_empty == 1'b1 && rx_full == 1'b0, "R1 buffer after reset",
              int'({rx_empty, rx_full}), 2);

        // transmit sweep: every divide, parity and flag setting
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++)
                for (int m = 0; m < 2; m++)
                    tx_frame(2'(s), 2'(p), 1'(m), 8'(8'hA5 ^ (s*37 + p*11 + m*3)), 1'(s ^ p ^ 1));

        // receive sweep with parity and framing errors mixed in
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++)
                for (int m = 0; m < 2; m++) begin
                    int e = (s + p + m) % 3;
                    rx_frame(2'(s), 2'(p), 1'(m), 8'((8'h5A ^ (s*29 + p*7 + m*3)) | 1),
                             1'(p ^ m), e == 1, e != 2);
                end

        // R5: short start glitches are ignored
        for (int s = 1; s < 4; s++) begin
            @(negedge clk);
            div_sel = 2'(s); par_mode = 2'd0; mp_en = 1'b0;
            rxd = 1'b0;
            repeat (div_of(2'(s))/2 - 2) @(negedge clk);
            rxd = 1'b1;
            repeat (3*div_of(2'(s))) @(negedge clk);
            check(rx_empty == 1'b1, "R5 glitch ignored", int'(rx_empty), 1);
        end

        // R7: break frame in odd parity with flag bit on
        @(negedge clk);
        div_sel = 2'd1; par_mode = 2'd2; mp_en = 1'b1;
        rxd = 1'b0;
        repeat (12*16 + 40) @(negedge clk);
        rxd = 1'b1;
        repeat (20) @(negedge clk);
        pop_check(8'h00, 5'b10000, "R7 break entry");
        check(rx_empty == 1'b1, "R7 single break entry", int'(rx_empty), 1);

        // R8: break send holds line low and blocks writes
        @(negedge clk);
        div_sel = 2'd1; par_mode = 2'd0; mp_en = 1'b0;
        brk_send = 1'b1;
        @(negedge clk);
        check(txd == 1'b0, "R8 break drives low", int'(txd), 0);
        tx_data = 8'hFF; tx_we = 1'b1;
        @(negedge clk);
        tx_we = 1'b0;
        repeat (5) @(negedge clk);
        check(tx_busy == 1'b0 && txd == 1'b0, "R8 write ignored during break",
              int'({tx_busy, txd}), 0);
        brk_send = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R8 line released", int'(txd), 1);

        // R9 R10 R11: fill, overrun, drain, empty read
        begin
            logic [11:0] bits;
            int nb;
            @(negedge clk);
            div_sel = 2'd0; par_mode = 2'd0; mp_en = 1'b0;
            for (int i = 0; i < 32; i++) begin
                if (i == 31) check(rx_full == 1'b0, "R9 not full at 31", int'(rx_full), 0);
                nb = build(8'(i + 1), 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, bits);
                drive_rx(bits, nb, 1);
            end
            check(rx_full == 1'b1, "R9 full at 32", int'(rx_full), 1);
            nb = build(8'h77, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, bits);
            drive_rx(bits, nb, 1);
            for (int i = 0; i < 32; i++)
                pop_check(8'(i + 1), 5'b00000, "R9/R10 order and discard");
            check(rx_empty == 1'b1, "R10 overrun char discarded", int'(rx_empty), 1);
            rx_re = 1'b1;
            @(negedge clk);
            rx_re = 1'b0;
            @(negedge clk);
            check(rx_empty == 1'b1 && rx_full == 1'b0, "R11 empty read no effect",
                  int'({rx_empty, rx_full}), 2);
            nb = build(8'h3C, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, bits);
            drive_rx(bits, nb, 1);
            pop_check(8'h3C, 5'b01000, "R10/R11 overrun flag on next char");
            check(rx_empty == 1'b1, "R11 single entry after empty read", int'(rx_empty), 1);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule